// File: doc/BRIEF.md
# Operand Barrel Shifter

This block forms the second operand of a 32-bit RISC data path together with the carry that a shift produces. A register value is moved by one of four shift kinds (logical left, logical right, arithmetic right, rotate right). The count comes from a 5-bit field carried in the instruction, or from the bottom byte of a second register. Two further modes cover the other ways an operand is formed. One is a one-bit rotate that pulls the incoming carry flag into the top bit. The other builds a 32-bit constant by rotating an 8-bit field right by twice a 4-bit rotation code.

The datapath is combinational: a mode multiplexer feeds one logarithmic shifter, and the rotated-constant path reuses that shifter. The operand and carry are then captured in an output register, so a result is visible one clock after its inputs. The register file, the ALU and the flag register sit outside the block.

Top module: `shf_operand_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `opnd_o` and `carry_o` become zero.
- R2: Outputs are registered: inputs applied before a rising edge appear on `opnd_o`/`carry_o` after that edge, and not before it.
- R3: In `mode_i` 0 (count = `amt_imm_i`) and in mode 1 (count = `amt_reg_i[7:0]`), a count of zero passes the value through unchanged and passes `carry_i` through to `carry_o`, for every shift kind.
- R4: `kind_i` 0 is logical left (the same code also serves as arithmetic left). For a count n in 1..31 the result is `src_i << n` and the carry is bit 32-n of `src_i`.
- R5: `kind_i` 1 (logical right) and `kind_i` 2 (arithmetic right) shift right by n in 1..31. Kind 1 fills with zeros and kind 2 fills with `src_i[31]`. In both, the carry is bit n-1 of `src_i`.
- R6: `kind_i` 3 rotates right by the count modulo 32, with the carry equal to the last bit rotated out. A nonzero count that is a multiple of 32 leaves the value unchanged and gives carry `src_i[31]`.
- R7: In mode 1 only `amt_reg_i[7:0]` sets the count; bits 31:8 have no effect on either output.
- R8: A mode-1 logical shift by exactly 32 gives zero with carry `src_i[0]` (left) or `src_i[31]` (right). A count above 32 gives zero with carry 0.
- R9: A mode-1 arithmetic right shift by 32 or more gives 32 copies of `src_i[31]`, and the carry equals `src_i[31]`.
- R10: `mode_i` 3 gives `{carry_i, src_i[31:1]}` with carry `src_i[0]`.
- R11: `mode_i` 2 gives `imm_i` zero-extended and rotated right by 2×`rot_i`. The carry is `carry_i` when `rot_i` is 0 and bit 31 of the result otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 field count, 1 register count, 2 rotated constant, 3 one-bit rotate through carry |
| kind_i | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| src_i | input | 32 | Value to be shifted |
| amt_reg_i | input | 32 | Register holding the count (bottom byte used) |
| amt_imm_i | input | 5 | Count from the instruction field |
| imm_i | input | 8 | Constant byte for mode 2 |
| rot_i | input | 4 | Rotation code for mode 2 (rotate by twice this value) |
| carry_i | input | 1 | Current carry flag |
| opnd_o | output | 32 | Registered shifted operand |
| carry_o | output | 1 | Registered shifter carry-out |

## Verification
The hardest cases come from register counts. At 32 the result is zero but the carry still holds one bit of the operand. Above 32 the carry drops to zero, and a multiple of 32 under rotate returns the operand untouched. Upper register bits must not change any of this. The bench sweeps register counts across 0..40 and a set of larger values up to 255. Each count is placed under random upper bits, with several operand patterns, both carry values and every kind. A one-bit-at-a-time reference that walks the full count decides each expected value.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } shf_kind_e;

  typedef enum logic [1:0] {
    MODE_IMM_CNT = 2'd0,
    MODE_REG_CNT = 2'd1,
    MODE_ROT_IMM = 2'd2,
    MODE_RRX     = 2'd3
  } shf_mode_e;

endpackage

// File: rtl/shf_operand_mux.sv
module shf_operand_mux
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  shf_mode_e           mode,
  input  shf_kind_e           kind,
  input  logic [DATA_W-1:0]   src,
  input  logic [DATA_W-1:0]   amt_reg,
  input  logic [AMT_W-1:0]    amt_imm,
  input  logic [IMM_W-1:0]    imm,
  input  logic [ROT_W-1:0]    rot,
  output logic [DATA_W-1:0]   sh_val,
  output shf_kind_e           sh_kind,
  output logic [CNT_W-1:0]    sh_cnt
);

  logic [DATA_W-1:0] imm_ext;
  logic [CNT_W-1:0]  rot_cnt;
  logic              unused_amt_hi;

  assign imm_ext       = DATA_W'(imm);
  assign rot_cnt       = CNT_W'({rot, 1'b0});
  assign unused_amt_hi = ^amt_reg[DATA_W-1:CNT_W];

  always_comb begin
    sh_val  = src;
    sh_kind = kind;
    sh_cnt  = CNT_W'(amt_imm);
    unique case (mode)
      MODE_IMM_CNT: sh_cnt = CNT_W'(amt_imm);
      MODE_REG_CNT: sh_cnt = amt_reg[CNT_W-1:0];
      MODE_ROT_IMM: begin
        sh_val  = imm_ext;
        sh_kind = KIND_ROR;
        sh_cnt  = rot_cnt;
      end
      MODE_RRX: begin
        sh_kind = KIND_ROR;
        sh_cnt  = CNT_W'(1);
      end
      default: sh_cnt = '0;
    endcase
  end

endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  shf_kind_e         kind,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic [DATA_W-1:0] val_rev;
  logic [DATA_W-1:0] work;
  logic [DATA_W-1:0] out_rev;
  logic [DATA_W-1:0] stg [AMT_W+1];
  logic [AMT_W-1:0]  mod_cnt;
  logic [AMT_W-1:0]  mod_dec;
  logic              cnt_zero;
  logic              cnt_big;
  logic              cnt_eq;
  logic              sign;
  logic              is_left;

  assign is_left  = (kind == KIND_LSL);
  assign sign     = val[DATA_W-1];
  assign mod_cnt  = cnt[AMT_W-1:0];
  assign mod_dec  = mod_cnt - AMT_W'(1);
  assign cnt_zero = (cnt == '0);
  assign cnt_big  = (cnt >= CNT_W'(DATA_W));
  assign cnt_eq   = (cnt == CNT_W'(DATA_W));

  // Left shifts run through the right-shift stages on a bit-reversed word.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign val_rev[i] = val[DATA_W-1-i];
    assign out_rev[i] = stg[AMT_W][DATA_W-1-i];
  end

  assign work   = is_left ? val_rev : val;
  assign stg[0] = work;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [SH-1:0] fill;
    always_comb begin
      unique case (kind)
        KIND_ROR: fill = stg[s][SH-1:0];
        KIND_ASR: fill = {SH{sign}};
        default:  fill = '0;
      endcase
    end
    assign stg[s+1] = mod_cnt[s] ? {fill, stg[s][DATA_W-1:SH]} : stg[s];
  end

  always_comb begin
    if (cnt_zero) begin
      res  = val;
      cout = cin;
    end else if (kind == KIND_ROR) begin
      res  = stg[AMT_W];
      cout = (mod_cnt == '0) ? val[DATA_W-1] : val[mod_dec];
    end else if (cnt_big) begin
      if (kind == KIND_ASR) begin
        res  = {DATA_W{sign}};
        cout = sign;
      end else begin
        res  = '0;
        cout = cnt_eq ? work[DATA_W-1] : 1'b0;
      end
    end else begin
      res  = is_left ? out_rev : stg[AMT_W];
      cout = work[mod_dec];
    end
  end

endmodule

// File: rtl/shf_operand_unit.sv
module shf_operand_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] amt_reg_i,
  input  logic [AMT_W-1:0]  amt_imm_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] opnd_o,
  output logic              carry_o
);

  shf_mode_e         mode;
  shf_kind_e         kind;
  logic [DATA_W-1:0] sh_val;
  shf_kind_e         sh_kind;
  logic [CNT_W-1:0]  sh_cnt;
  logic [DATA_W-1:0] core_res;
  logic              core_cout;
  logic [DATA_W-1:0] nxt_opnd;
  logic              nxt_carry;

  assign mode = shf_mode_e'(mode_i);
  assign kind = shf_kind_e'(kind_i);

  shf_operand_mux #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
  ) u_mux (
    .mode    (mode),
    .kind    (kind),
    .src     (src_i),
    .amt_reg (amt_reg_i),
    .amt_imm (amt_imm_i),
    .imm     (imm_i),
    .rot     (rot_i),
    .sh_val  (sh_val),
    .sh_kind (sh_kind),
    .sh_cnt  (sh_cnt)
  );

  shf_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .val  (sh_val),
    .kind (sh_kind),
    .cnt  (sh_cnt),
    .cin  (carry_i),
    .res  (core_res),
    .cout (core_cout)
  );

  // Rotate-through-carry: the core's one-bit rotate supplies bit 0 as carry,
  // and the top bit is replaced by the incoming flag.
  always_comb begin
    nxt_opnd  = core_res;
    nxt_carry = core_cout;
    if (mode == MODE_RRX) nxt_opnd[DATA_W-1] = carry_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_o  <= '0;
      carry_o <= 1'b0;
    end else begin
      opnd_o  <= nxt_opnd;
      carry_o <= nxt_carry;
    end
  end

  // R3
  zero_cnt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 && amt_imm_i == '0) |=>
      (opnd_o == $past(src_i) && carry_o == $past(carry_i)));

  // R6
  ror_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && kind_i == 2'd3 && amt_reg_i[CNT_W-1:0] != '0 &&
     amt_reg_i[AMT_W-1:0] == '0) |=>
      (opnd_o == $past(src_i) && carry_o == $past(src_i[DATA_W-1])));

  // R8
  lsr_over_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && kind_i == 2'd1 && amt_reg_i[CNT_W-1:0] > CNT_W'(DATA_W)) |=>
      (opnd_o == '0 && !carry_o));

  // R9
  asr_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1 && kind_i == 2'd2 && amt_reg_i[CNT_W-1:0] >= CNT_W'(DATA_W)) |=>
      (opnd_o == {DATA_W{$past(src_i[DATA_W-1])}} && carry_o == $past(src_i[DATA_W-1])));

  // R10
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd3) |=>
      (opnd_o == {$past(carry_i), $past(src_i[DATA_W-1:1])} && carry_o == $past(src_i[0])));

  // R11
  rot_imm_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2 && rot_i != '0) |=> (carry_o == opnd_o[DATA_W-1]));

  // R11
  rot_imm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd2 && rot_i == '0) |=>
      (opnd_o == DATA_W'($past(imm_i)) && carry_o == $past(carry_i)));

endmodule

// File: tb/tb_shf_operand_unit.sv
module tb_shf_operand_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = '0;
  logic [1:0]  kind_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] amt_reg_i = '0;
  logic [4:0]  amt_imm_i = '0;
  logic [7:0]  imm_i = '0;
  logic [3:0]  rot_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] opnd_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_operand_unit dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .kind_i(kind_i), .src_i(src_i),
    .amt_reg_i(amt_reg_i), .amt_imm_i(amt_imm_i), .imm_i(imm_i), .rot_i(rot_i),
    .carry_i(carry_i), .opnd_o(opnd_o), .carry_o(carry_o)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  // Reference: one bit per step, full count walked.
  function automatic logic [32:0] ref_model(input logic [1:0] md, input logic [1:0] kd,
      input logic [31:0] v, input logic [31:0] areg, input logic [4:0] aimm,
      input logic ci, input logic [7:0] im, input logic [3:0] rt);
    logic [31:0] r;
    logic c;
    int n;
    r = v;
    c = ci;
    if (md == 2'd3) begin
      r = {ci, v[31:1]};
      c = v[0];
    end else if (md == 2'd2) begin
      r = {24'd0, im};
      n = 2 * int'(rt);
      for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
      if (n != 0) c = r[31];
    end else begin
      n = (md == 2'd0) ? int'(aimm) : int'(areg[7:0]);
      for (int i = 0; i < n; i++) begin
        case (kd)
          2'd0: begin c = r[31]; r = r << 1; end
          2'd1: begin c = r[0];  r = r >> 1; end
          2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
          default: begin c = r[0]; r = {r[0], r[31:1]}; end
        endcase
      end
    end
    return {c, r};
  endfunction

  task automatic check(input string req, input logic [31:0] exp_o, input logic exp_c);
    checks++;
    if (opnd_o !== exp_o || carry_o !== exp_c) begin
      errors++;
      $display("FAIL %s: got opnd=%h carry=%b expected opnd=%h carry=%b",
               req, opnd_o, carry_o, exp_o, exp_c);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] md, input logic [1:0] kd,
      input logic [31:0] v, input logic [31:0] areg, input logic [4:0] aimm,
      input logic ci, input logic [7:0] im, input logic [3:0] rt);
    logic [32:0] e;
    @(negedge clk);
    mode_i = md; kind_i = kd; src_i = v; amt_reg_i = areg; amt_imm_i = aimm;
    carry_i = ci; imm_i = im; rot_i = rt;
    e = ref_model(md, kd, v, areg, aimm, ci, im, rt);
    @(negedge clk);
    check(req, e[31:0], e[32]);
  endtask

  function automatic string tag_for(input logic [1:0] md, input logic [1:0] kd, input int n);
    if (n == 0) return "R3";
    if (md == 2'd1 && n >= 32) begin
      if (kd == 2'd3) return "R6";
      if (kd == 2'd2) return "R9";
      return "R8";
    end
    if (kd == 2'd0) return "R4";
    if (kd == 2'd3) return "R6";
    return "R5";
  endfunction

  logic [31:0] vals [6] = '{32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000,
                            32'h7FFF_0F0A, 32'hDEAD_BEEF, 32'h1234_5678};
  int reg_cnts [10] = '{63, 64, 96, 127, 128, 160, 200, 224, 254, 255};

  initial begin
    logic [32:0] e;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'd0, 1'b0);
    rst = 1'b0;

    // R2: output changes only after the edge
    apply("R2", 2'd0, 2'd1, 32'hF0F0_0000, 32'd0, 5'd4, 1'b0, 8'd0, 4'd0);
    @(negedge clk);
    mode_i = 2'd3; src_i = 32'h0000_0003; carry_i = 1'b1;
    #1 check("R2", 32'h0F0F_0000, 1'b0);
    e = ref_model(2'd3, 2'd0, 32'h3, 32'd0, 5'd0, 1'b1, 8'd0, 4'd0);
    @(negedge clk);
    check("R2", e[31:0], e[32]);

    // Field-count sweep
    for (int vi = 0; vi < 6; vi++)
      for (int k = 0; k < 4; k++)
        for (int ci = 0; ci < 2; ci++)
          for (int n = 0; n < 32; n++)
            apply(tag_for(2'd0, 2'(k), n), 2'd0, 2'(k), vals[vi], lfsr, 5'(n),
                  1'(ci), 8'd0, 4'd0);

    // Register-count sweep with random upper bits
    for (int vi = 0; vi < 6; vi++)
      for (int k = 0; k < 4; k++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int n = 0; n <= 40; n++) begin
            lfsr = next_rand(lfsr);
            apply(tag_for(2'd1, 2'(k), n), 2'd1, 2'(k), vals[vi],
                  {lfsr[31:8], 8'(n)}, 5'd0, 1'(ci), 8'd0, 4'd0);
          end
          for (int j = 0; j < 10; j++) begin
            lfsr = next_rand(lfsr);
            apply(tag_for(2'd1, 2'(k), reg_cnts[j]), 2'd1, 2'(k), vals[vi],
                  {lfsr[31:8], 8'(reg_cnts[j])}, 5'd0, 1'(ci), 8'd0, 4'd0);
          end
        end

    // R7: same low byte, different upper bits, same result
    for (int t = 0; t < 40; t++) begin
      lfsr = next_rand(lfsr);
      apply("R7", 2'd1, 2'(t % 4), 32'hC3A5_0F96, {24'd0, 8'(t * 7)}, 5'd0, 1'(t % 2), 8'd0, 4'd0);
      apply("R7", 2'd1, 2'(t % 4), 32'hC3A5_0F96, {lfsr[31:8] | 24'h1, 8'(t * 7)}, 5'd0,
            1'(t % 2), 8'd0, 4'd0);
    end

    // R11: rotated constant, all rotation codes
    for (int r = 0; r < 16; r++)
      for (int ci = 0; ci < 2; ci++) begin
        apply("R11", 2'd2, 2'd0, 32'hFFFF_FFFF, 32'd0, 5'd0, 1'(ci), 8'h01, 4'(r));
        apply("R11", 2'd2, 2'd1, 32'h0, 32'd0, 5'd0, 1'(ci), 8'h80, 4'(r));
        apply("R11", 2'd2, 2'd2, 32'h0, 32'd0, 5'd0, 1'(ci), 8'hFF, 4'(r));
        apply("R11", 2'd2, 2'd3, 32'h0, 32'd0, 5'd0, 1'(ci), 8'hA5, 4'(r));
      end

    // R10: rotate through carry
    for (int vi = 0; vi < 6; vi++)
      for (int ci = 0; ci < 2; ci++)
        apply("R10", 2'd3, 2'(vi % 4), vals[vi], 32'd5, 5'd7, 1'(ci), 8'd0, 4'd0);

    // R1: reset again clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 32'd0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule